// File: doc/BRIEF.md
# Secret button sequence detector

The detector watches a strobe that marks each push-button press together with the index of the pressed button. It keeps a shift history of the last nine indices and counts presses in blocks of nine. On the ninth press of each block it compares the whole history, including that ninth press, against two fixed nine-entry code sequences. It emits a single-cycle pulse on the output that belongs to the sequence that matched. The press count then restarts from zero.

The comparison is made once per block of nine presses, never as a sliding window. The oldest press in the history is compared with the first element of each sequence. Both sequences are checked in the same pass. Debouncing of the buttons is assumed to happen upstream. Whatever a match triggers happens downstream.

Top module: `seq_detect`

## Requirements
- R1: A synchronous active-low reset clears the press count to zero and fills the history with the invalid index 15. While reset is low, no pulse is produced. After reset, nothing can match until nine presses have been made.
- R2: Every cycle with `press_vld` high counts as one press, whatever its index. Cycles with `press_vld` low change neither the count nor the history, whatever value `press_idx` holds.
- R3: The comparison runs only on the 9th, 18th, 27th … press after reset, which are fixed blocks of nine. A code sequence that straddles two blocks produces no pulse.
- R4: If the nine presses of a block, oldest first, are 4,3,2,1,0,1,2,3,4, then `match_a` is high for the one clock cycle after the edge that captured the ninth press.
- R5: If the nine presses of a block, oldest first, are 0,1,0,1,4,3,4,3,2, then `match_b` is high for the one clock cycle after the edge that captured the ninth press.
- R6: Each pulse lasts exactly one cycle. A block that matches neither sequence produces no pulse. The two outputs are never high together.
- R7: Order matters. The second sequence entered newest-first (2,3,4,3,4,1,0,1,0) produces no pulse.
- R8: `press_idx` is 4 bits wide. Indices 10 to 15 count as presses but can never be part of a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| press_vld | input | 1 | One-cycle strobe per button press |
| press_idx | input | 4 | Index of the pressed button, 0 = leftmost |
| match_a | output | 1 | Pulse: the block equals the first sequence |
| match_b | output | 1 | Pulse: the block equals the second sequence |

## Verification
The assertions check on every cycle that:
- each pulse follows a press that closed a block;
- each pulse lasts one cycle;
- the two pulses never coincide;
- the count advances only on presses and stays below nine.

Whether the right sequence, in the right order and block alignment, raised the right pulse can only be shown by the bench's scenarios. These include the misaligned and reversed sequences, idle cycles that carry pattern values on `press_idx`, out-of-range indices, and a reset in the middle of a block.

// File: rtl/seq_detect_pkg.sv
// Shared constants for the sequence detector: widths, block length and the
// two code sequences. Element 0 of each sequence is the oldest press.
package seq_detect_pkg;
    localparam int IDX_W   = 4;
    localparam int DEPTH   = 9;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam logic [IDX_W-1:0] IDX_INVALID = '1;

    typedef logic [DEPTH-1:0][IDX_W-1:0] window_t;

    // Packed: leftmost literal is element DEPTH-1 (newest).
    localparam window_t SEQ_A = {4'd4, 4'd3, 4'd2, 4'd1, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4};
    localparam window_t SEQ_B = {4'd2, 4'd3, 4'd4, 4'd3, 4'd4, 4'd1, 4'd0, 4'd1, 4'd0};
endpackage

// File: rtl/seq_history.sv
// Shift history of the last DEPTH press indices. Element 0 is the oldest.
// win_o presents the history as it will be after the current press, so
// that a comparator can judge the ninth press in the same cycle.
// Assumes press_vld is already a clean one-cycle strobe.
module seq_history
    import seq_detect_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             press_vld,
    input  logic [IDX_W-1:0] press_idx,
    output window_t          win_o
);
    window_t hist_q;

    // Build the look-ahead window: shifted history plus incoming index.
    always_comb begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            win_o[i] = hist_q[i+1];
        end
        win_o[DEPTH-1] = press_idx;
    end

    // Shift on each press; reset fills every entry with the invalid code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_q[i] <= IDX_INVALID;
            end
        end else if (press_vld) begin
            hist_q <= win_o;
        end
    end
endmodule

// File: rtl/seq_press_count.sv
// Counts presses modulo DEPTH. block_end is high in the cycle when the
// press that closes the current block is presented.
module seq_press_count
    import seq_detect_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             press_vld,
    output logic [CNT_W-1:0] cnt_o,
    output logic             block_end
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEPTH - 1);

    logic [CNT_W-1:0] cnt_q;

    // Flag the closing press of the block.
    assign block_end = press_vld && (cnt_q == LAST);
    assign cnt_o     = cnt_q;

    // Advance on every press; wrap to zero after the closing press.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (block_end) begin
            cnt_q <= '0;
        end else if (press_vld) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/seq_matcher.sv
// Compares the look-ahead window element by element with one fixed code
// sequence and registers a one-cycle pulse when a block closes on a match.
module seq_matcher
    import seq_detect_pkg::*;
#(
    parameter window_t SEQ = SEQ_A
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    check,
    input  window_t win_i,
    output logic    hit_o
);
    logic [DEPTH-1:0] elem_eq;
    logic             hit_q;

    // Per-element equality; the whole vector must be set for a match.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            elem_eq[i] = (win_i[i] == SEQ[i]);
        end
    end

    // Register the pulse only on the closing press of a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= check && (&elem_eq);
        end
    end

    assign hit_o = hit_q;
endmodule

// File: rtl/seq_detect.sv
// Top of the sequence detector: history, block counter and one matcher
// per code sequence, all judged on the same closing press.
module seq_detect
    import seq_detect_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             press_vld,
    input  logic [IDX_W-1:0] press_idx,
    output logic             match_a,
    output logic             match_b
);
    localparam int NSEQ = 2;
    localparam window_t SEQS [NSEQ] = '{SEQ_A, SEQ_B};

    window_t          win;
    logic [CNT_W-1:0] cnt;
    logic             block_end;
    logic [NSEQ-1:0]  hits;

    seq_history u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .press_vld (press_vld),
        .press_idx (press_idx),
        .win_o     (win)
    );

    seq_press_count u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .press_vld (press_vld),
        .cnt_o     (cnt),
        .block_end (block_end)
    );

    // One comparator per sequence, run in parallel.
    for (genvar s = 0; s < NSEQ; s++) begin : g_match
        seq_matcher #(.SEQ(SEQS[s])) u_m (
            .clk   (clk),
            .rst_n (rst_n),
            .check (block_end),
            .win_i (win),
            .hit_o (hits[s])
        );
    end

    assign match_a = hits[0];
    assign match_b = hits[1];
endmodule

// File: rtl/seq_detect_chk.sv
// Checker for seq_detect, attached by bind. Watches the ports and the
// internal block count.
module seq_detect_chk
    import seq_detect_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             press_vld,
    input logic [CNT_W-1:0] cnt,
    input logic             match_a,
    input logic             match_b
);
    // R6
    excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_a && match_b));

    // R6
    one_cycle_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_a |=> !match_a);

    // R6
    one_cycle_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_b |=> !match_b);

    // R3
    pulse_after_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a || match_b) |-> ($past(press_vld) && $past(cnt) == CNT_W'(DEPTH - 1)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !press_vld |=> $stable(cnt));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (press_vld && cnt != CNT_W'(DEPTH - 1)) |=> cnt == $past(cnt) + 1'b1);

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(DEPTH));
endmodule

bind seq_detect seq_detect_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .press_vld (press_vld),
    .cnt       (cnt),
    .match_a   (match_a),
    .match_b   (match_b)
);

// File: tb/sim_seq_detect.sv
module sim_seq_detect;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       press_vld = 1'b0;
    logic [3:0] press_idx = '0;
    logic       match_a, match_b;

    int vectors = 0;
    int errors  = 0;

    // Bench model state
    int  m_hist [9];
    int  m_cnt;
    bit  exp_a, exp_b;

    localparam int PA [9] = '{4, 3, 2, 1, 0, 1, 2, 3, 4};
    localparam int PB [9] = '{0, 1, 0, 1, 4, 3, 4, 3, 2};
    localparam int PBR [9] = '{2, 3, 4, 3, 4, 1, 0, 1, 0};

    seq_detect u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .press_vld (press_vld),
        .press_idx (press_idx),
        .match_a   (match_a),
        .match_b   (match_b)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic bit win_eq(input int h [9], input int p [9]);
        for (int i = 0; i < 9; i++) begin
            if (h[i] != p[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Model update for one clock edge, from the requirements.
    task automatic model_edge(input bit rn, input bit v, input int idx);
        exp_a = 1'b0;
        exp_b = 1'b0;
        if (!rn) begin
            for (int i = 0; i < 9; i++) m_hist[i] = 15;
            m_cnt = 0;
        end else if (v) begin
            for (int i = 0; i < 8; i++) m_hist[i] = m_hist[i+1];
            m_hist[8] = idx;
            if (m_cnt == 8) begin
                m_cnt = 0;
                exp_a = win_eq(m_hist, PA);
                exp_b = win_eq(m_hist, PB);
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    endtask

    // Apply one cycle of stimulus, then check both outputs after the edge.
    task automatic cyc(input bit rn, input bit v, input int idx, input string tag);
        @(negedge clk);
        rst_n     = rn;
        press_vld = v;
        press_idx = idx[3:0];
        @(posedge clk);
        model_edge(rn, v, idx);
        #1;
        vectors++;
        if (match_a !== exp_a || match_b !== exp_b) begin
            errors++;
            $display("FAIL %s: match_a/match_b = %0b%0b, expected %0b%0b",
                     tag, match_a, match_b, exp_a, exp_b);
        end
    endtask

    task automatic press_seq(input int p [9], input string tag);
        for (int i = 0; i < 9; i++) cyc(1'b1, 1'b1, p[i], tag);
        cyc(1'b1, 1'b0, 0, tag);
    endtask

    task automatic expect_pulse(input bit a, input bit b, input string tag);
        vectors++;
        if (exp_a !== a || exp_b !== b) begin
            errors++;
            $display("FAIL %s: model pulses %0b%0b, expected %0b%0b", tag, exp_a, exp_b, a, b);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state, and presses are ignored while reset is low
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 4, "R1 reset");
        // R4: sequence A, oldest first
        for (int i = 0; i < 9; i++) begin
            cyc(1'b1, 1'b1, PA[i], "R4 seq A");
        end
        expect_pulse(1'b1, 1'b0, "R4 seq A pulse");
        // R6: pulse lasts one cycle
        cyc(1'b1, 1'b0, 0, "R6 one cycle");
        // R5: sequence B
        for (int i = 0; i < 9; i++) cyc(1'b1, 1'b1, PB[i], "R5 seq B");
        expect_pulse(1'b0, 1'b1, "R5 seq B pulse");
        cyc(1'b1, 1'b0, 0, "R6 one cycle");
        // R2: idle cycles carrying pattern values do nothing, then B with gaps
        for (int i = 0; i < 9; i++) begin
            cyc(1'b1, 1'b0, PA[i], "R2 idle");
            cyc(1'b1, 1'b1, PB[i], "R2 gapped B");
        end
        expect_pulse(1'b0, 1'b1, "R2 gapped B pulse");
        // R3: misaligned by one press -> sequence straddles blocks
        cyc(1'b1, 1'b1, 7, "R3 offset");
        press_seq(PA, "R3 misaligned A");
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b1, 9, "R3 realign");
        // R7: reversed sequence B
        press_seq(PBR, "R7 reversed B");
        // R8: out-of-range indices count but never match
        for (int i = 0; i < 9; i++) cyc(1'b1, 1'b1, 10 + (i % 6), "R8 high index");
        press_seq(PA, "R8 aligned A after high indices");
        expect_pulse(1'b0, 1'b0, "R8 idle after");
        // R1: reset in mid-block restarts the count
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1, "R1 partial");
        cyc(1'b0, 1'b0, 0, "R1 mid reset");
        press_seq(PB, "R1 B after reset");
        // Random traffic with idle gaps, occasional planted sequences
        for (int n = 0; n < 600; n++) begin
            int r = $urandom_range(0, 19);
            if (r == 0) press_seq(PA, "R4 random A");
            else if (r == 1) press_seq(PB, "R5 random B");
            else cyc(1'b1, $urandom_range(0, 3) != 0, $urandom_range(0, 15), "R3 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule